// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block is the per-processor half of a two-level interrupt controller. A source layer offers it interrupt requests, each a source number with a priority. The block keeps at most one of them pending. A newer request can displace the pending one by being more favoured, and a request that loses is handed back to the source layer as a reject. A separate inter-processor priority register lets software inject a reserved source number. That source competes with external requests on the same priority scale. The block drives one interrupt line toward the processor.

The processor talks to the block through four commands on a valid/opcode/data port, at most one per cycle: set the current priority, write the inter-processor priority, accept, and end-of-interrupt. The pending register packs the current priority into bits 31:24 and the pending source number into bits 23:0. A source number of zero means nothing is pending. Priorities compare numerically, so a lower value is more favoured and 0xFF is the least favoured. Reject, resend and end-of-interrupt notices go back to the source layer as registered single-cycle pulses. A source request and a command are never presented in the same cycle; if they are, the command is served and the request is dropped.

Top module: `cpu_irq_presenter`

## Requirements
- R1: After reset the pending register reads 0, the interrupt line is low, no notification pulse is active, and the inter-processor priority is 0xFF.
- R2: A request whose priority is numerically greater than or equal to the current priority is turned away. In the cycle after the request, a reject pulse carries its source number, and the pending state does not change.
- R3: A request is turned away with a reject pulse for its own source number when a source is already pending whose priority is less than or equal to the request's.
- R4: A request that is not turned away is latched with its priority and raises the interrupt line. If another source was pending, that source is rejected in the cycle after the request.
- R5: Opcode 2 (accept) presents the whole pending register on `acc_data` in the cycle the command is valid. After the edge, the interrupt line is low, the current priority equals the old pending priority, the source field is 0 and the pending priority is 0xFF.
- R6: Opcode 1 stores `cmd_data[7:0]` as the inter-processor priority. When that value is below the current priority, and no pending source has a priority at or below it, any pending source is rejected, source number 2 is latched with that priority and the line is raised. Otherwise nothing else changes.
- R7: Opcode 0 loads `cmd_data[7:0]` as the current priority. When the new value is lower than the old one, a source is pending, and the new value is at or below that source's priority, the source is cleared and rejected and the line drops.
- R8: When opcode 0 loads a value equal to or above the old current priority while nothing is pending, a resend pulse is issued. If the inter-processor priority is below the new current priority, source 2 is also latched at that priority.
- R9: Opcode 3 (end-of-interrupt) copies `cmd_data[31:24]` into the current priority and pulses an end-of-interrupt notice carrying `cmd_data[23:0]`. When nothing is pending, it also performs the resend of R8.
- R10: The interrupt line is high exactly when the source field is nonzero.
- R11: A request with source number 0 is ignored. It causes no reject and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Source request strobe |
| req_src | input | 24 | Requested source number |
| req_prio | input | 8 | Requested priority |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 2 | 0 set priority, 1 inter-processor priority, 2 accept, 3 end-of-interrupt |
| cmd_data | input | 32 | Command operand |
| acc_data | output | 32 | Pending register, consumed by accept |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse to the source layer |
| rej_src | output | 24 | Rejected source number |
| resend_pulse | output | 1 | Ask the source layer to re-offer rejected sources |
| eoi_valid | output | 1 | End-of-interrupt pulse to the source layer |
| eoi_src | output | 24 | Source number being retired |

## Verification
The bench aims at equal-priority boundaries. These are a request at exactly the current priority, a request tied with the pending priority, and an inter-processor priority equal to a pending one. A design that used strict where it should use non-strict comparison would latch where it must reject, or the reverse. Preemption is checked for a reject of the displaced source. Without one, the source layer would lose an interrupt. Lowering the current priority onto the pending priority must clear and reject the pending source. A design that missed this would leave the line high. Resends triggered by raising the priority or by end-of-interrupt must inject the inter-processor source when its priority now wins. A design that skipped the check would never deliver that interrupt.

// File: rtl/cpu_irq_pres_pkg.sv
package cpu_irq_pres_pkg;

  localparam int PRIO_W = 8;
  localparam int SRC_W  = 24;
  localparam int REG_W  = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [SRC_W-1:0]  src_t;

  typedef enum logic [1:0] {
    OP_SET_CPPR = 2'd0,
    OP_SET_IPI  = 2'd1,
    OP_ACCEPT   = 2'd2,
    OP_EOI      = 2'd3
  } pres_op_e;

  // true when a candidate of priority p cannot get past the current priority
  function automatic logic gate_blocks(input prio_t p, input prio_t cur);
    return p >= cur;
  endfunction

  // true when an occupied pending slot holds something at least as favoured
  function automatic logic slot_holds(input logic busy, input prio_t held, input prio_t p);
    return busy && (held <= p);
  endfunction

  function automatic logic [REG_W-1:0] pack_pending(input prio_t cur, input src_t src);
    return {cur, src};
  endfunction

endpackage

// File: rtl/cpu_irq_req_arbiter.sv
module cpu_irq_req_arbiter
  import cpu_irq_pres_pkg::*;
(
  input  logic  req_live,
  input  prio_t req_prio,
  input  prio_t cur_prio,
  input  logic  slot_busy,
  input  prio_t slot_prio,
  output logic  take,
  output logic  self_reject,
  output logic  bump_old
);
  logic lose;

  always_comb begin
    lose        = gate_blocks(req_prio, cur_prio) || slot_holds(slot_busy, slot_prio, req_prio);
    self_reject = req_live && lose;
    take        = req_live && !lose;
    bump_old    = take && slot_busy;
  end
endmodule

// File: rtl/cpu_irq_ipi_unit.sv
module cpu_irq_ipi_unit
  import cpu_irq_pres_pkg::*;
(
  input  logic  check_en,
  input  prio_t ipi_prio,
  input  prio_t cur_prio,
  input  logic  slot_busy,
  input  prio_t slot_prio,
  output logic  inject,
  output logic  bump_old
);
  logic below;

  always_comb begin
    below    = !gate_blocks(ipi_prio, cur_prio);
    inject   = check_en && below && !slot_holds(slot_busy, slot_prio, ipi_prio);
    bump_old = inject && slot_busy;
  end
endmodule

// File: rtl/cpu_irq_notify.sv
module cpu_irq_notify
  import cpu_irq_pres_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rej_set,
  input  src_t rej_id,
  input  logic resend_set,
  input  logic eoi_set,
  input  src_t eoi_id,
  output logic rej_valid,
  output src_t rej_src,
  output logic resend_pulse,
  output logic eoi_valid,
  output src_t eoi_src
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rej_valid    <= 1'b0;
      rej_src      <= '0;
      resend_pulse <= 1'b0;
      eoi_valid    <= 1'b0;
      eoi_src      <= '0;
    end else begin
      rej_valid    <= rej_set;
      rej_src      <= rej_set ? rej_id : '0;
      resend_pulse <= resend_set;
      eoi_valid    <= eoi_set;
      eoi_src      <= eoi_set ? eoi_id : '0;
    end
  end

  // a reject always names a real source
  assert_reject_named_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_src != '0));
endmodule

// File: rtl/cpu_irq_presenter.sv
module cpu_irq_presenter
  import cpu_irq_pres_pkg::*;
#(
  parameter logic [23:0] IPI_SRC = 24'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [23:0] req_src,
  input  logic [7:0]  req_prio,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [31:0] cmd_data,
  output logic [31:0] acc_data,
  output logic        irq_out,
  output logic        rej_valid,
  output logic [23:0] rej_src,
  output logic        resend_pulse,
  output logic        eoi_valid,
  output logic [23:0] eoi_src
);
  localparam int CPPR_LO = SRC_W;

  prio_t cppr_q, pend_q, mfrr_q;
  src_t  xisr_q;
  logic  irq_q;

  prio_t cppr_n, pend_n, mfrr_n;
  src_t  xisr_n;
  logic  irq_n;

  pres_op_e op;
  logic  slot_busy, req_live;
  logic  is_accept, is_cppr, is_ipi, is_eoi;
  prio_t cmd_prio, cppr_after, ipi_sel;
  logic  cppr_drop, resend_evt, ipi_en;
  logic  arb_take, arb_self, arb_bump;
  logic  ipi_inject, ipi_bump;
  logic  rej_set;
  src_t  rej_id;

  assign op        = pres_op_e'(cmd_op);
  assign slot_busy = (xisr_q != '0);
  assign req_live  = req_valid && !cmd_valid && (req_src != '0);
  assign is_accept = cmd_valid && (op == OP_ACCEPT);
  assign is_cppr   = cmd_valid && (op == OP_SET_CPPR);
  assign is_ipi    = cmd_valid && (op == OP_SET_IPI);
  assign is_eoi    = cmd_valid && (op == OP_EOI);
  assign cmd_prio  = cmd_data[PRIO_W-1:0];

  always_comb begin
    cppr_after = cppr_q;
    if (is_cppr) cppr_after = cmd_prio;
    else if (is_eoi) cppr_after = cmd_data[REG_W-1:CPPR_LO];
  end

  // lowering the priority onto or below the pending one drops it
  assign cppr_drop  = is_cppr && (cmd_prio < cppr_q) && slot_busy && (cmd_prio <= pend_q);
  // resend occurs when nothing is pending after a raise or an end-of-interrupt
  assign resend_evt = !slot_busy && ((is_cppr && (cmd_prio >= cppr_q)) || is_eoi);
  assign ipi_en     = is_ipi || resend_evt;
  assign ipi_sel    = is_ipi ? cmd_prio : mfrr_q;

  cpu_irq_req_arbiter u_arb (
    .req_live    (req_live),
    .req_prio    (req_prio),
    .cur_prio    (cppr_q),
    .slot_busy   (slot_busy),
    .slot_prio   (pend_q),
    .take        (arb_take),
    .self_reject (arb_self),
    .bump_old    (arb_bump)
  );

  cpu_irq_ipi_unit u_ipi (
    .check_en  (ipi_en),
    .ipi_prio  (ipi_sel),
    .cur_prio  (cppr_after),
    .slot_busy (slot_busy),
    .slot_prio (pend_q),
    .inject    (ipi_inject),
    .bump_old  (ipi_bump)
  );

  always_comb begin
    cppr_n = cppr_q;
    pend_n = pend_q;
    mfrr_n = mfrr_q;
    xisr_n = xisr_q;
    irq_n  = irq_q;
    if (is_accept) begin
      cppr_n = pend_q;
      pend_n = PRIO_NONE;
      xisr_n = '0;
      irq_n  = 1'b0;
    end else if (cmd_valid) begin
      cppr_n = cppr_after;
      if (is_ipi) mfrr_n = cmd_prio;
      if (cppr_drop) begin
        xisr_n = '0;
        pend_n = PRIO_NONE;
        irq_n  = 1'b0;
      end
      if (ipi_inject) begin
        xisr_n = IPI_SRC;
        pend_n = ipi_sel;
        irq_n  = 1'b1;
      end
    end else if (arb_take) begin
      xisr_n = req_src;
      pend_n = req_prio;
      irq_n  = 1'b1;
    end
  end

  assign rej_set = cppr_drop || ipi_bump || arb_self || arb_bump;
  assign rej_id  = arb_self ? req_src : xisr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q <= '0;
      xisr_q <= '0;
      pend_q <= PRIO_NONE;
      mfrr_q <= PRIO_NONE;
      irq_q  <= 1'b0;
    end else begin
      cppr_q <= cppr_n;
      xisr_q <= xisr_n;
      pend_q <= pend_n;
      mfrr_q <= mfrr_n;
      irq_q  <= irq_n;
    end
  end

  cpu_irq_notify u_notify (
    .clk          (clk),
    .rst_n        (rst_n),
    .rej_set      (rej_set),
    .rej_id       (rej_id),
    .resend_set   (resend_evt),
    .eoi_set      (is_eoi),
    .eoi_id       (cmd_data[SRC_W-1:0]),
    .rej_valid    (rej_valid),
    .rej_src      (rej_src),
    .resend_pulse (resend_pulse),
    .eoi_valid    (eoi_valid),
    .eoi_src      (eoi_src)
  );

  assign acc_data = pack_pending(cppr_q, xisr_q);
  assign irq_out  = irq_q;

  assert_line_follows_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (xisr_q != '0));

  assert_accept_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_accept |=> (!irq_out && (xisr_q == '0) && (pend_q == PRIO_NONE) && (cppr_q == $past(pend_q))));

  assert_take_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arb_take |=> (irq_out && (xisr_q == $past(req_src)) && (pend_q == $past(req_prio))));

  assert_ipi_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_inject |=> (irq_out && (xisr_q == IPI_SRC)));

  assert_drop_rejects_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cppr_drop |=> (!irq_out && rej_valid && (rej_src == $past(xisr_q))));

  assert_eoi_forwarded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_eoi |=> (eoi_valid && (eoi_src == $past(cmd_data[SRC_W-1:0]))));

  assert_null_source_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cmd_valid && (req_src == '0)) |=> ($stable(xisr_q) && !rej_valid));
endmodule

// File: tb/cpu_irq_presenter_test.sv
module cpu_irq_presenter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_src = '0;
  logic [7:0]  req_prio = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic [31:0] acc_data;
  logic        irq_out, rej_valid, resend_pulse, eoi_valid;
  logic [23:0] rej_src, eoi_src;

  always #2.5 clk = ~clk;

  cpu_irq_presenter uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .acc_data(acc_data), .irq_out(irq_out),
    .rej_valid(rej_valid), .rej_src(rej_src), .resend_pulse(resend_pulse),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference state
  logic [7:0]  m_cppr, m_pend, m_mfrr;
  logic [23:0] m_src;
  logic        e_rej, e_resend, e_eoi;
  logic [23:0] e_rej_src, e_eoi_src;
  string       tag;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pick_prio();
    case ($urandom % 7)
      0: return 8'h00;
      1: return 8'h03;
      2: return 8'h04;
      3: return 8'h05;
      4: return 8'hFF;
      5: return 8'h80;
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic clear_expect();
    e_rej = 0; e_rej_src = '0; e_resend = 0; e_eoi = 0; e_eoi_src = '0;
  endtask

  task automatic bounce(input logic [23:0] s);
    e_rej = 1; e_rej_src = s;
  endtask

  task automatic m_ipi(input logic [7:0] p);
    if (!(m_src != 0 && !(p < m_pend))) begin
      if (m_src != 0) bounce(m_src);
      m_src = 24'd2; m_pend = p;
    end
  endtask

  task automatic m_resend();
    if (m_mfrr < m_cppr) m_ipi(m_mfrr);
    e_resend = 1;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic check_outputs();
    chk(tag, {31'd0, irq_out}, {31'd0, m_src != 0});
    chk("R10", {31'd0, irq_out}, {31'd0, m_src != 0});
    chk(tag, {31'd0, rej_valid}, {31'd0, e_rej});
    if (e_rej) chk(tag, {8'd0, rej_src}, {8'd0, e_rej_src});
    chk(tag, {31'd0, resend_pulse}, {31'd0, e_resend});
    chk(tag, {31'd0, eoi_valid}, {31'd0, e_eoi});
    if (e_eoi) chk(tag, {8'd0, eoi_src}, {8'd0, e_eoi_src});
  endtask

  task automatic do_req(input logic [23:0] s, input logic [7:0] p);
    @(negedge clk);
    req_valid = 1; req_src = s; req_prio = p; cmd_valid = 0;
    clear_expect();
    if (s == 0) tag = "R11";
    else if (!(p < m_cppr)) begin tag = "R2"; bounce(s); end
    else if (m_src != 0 && !(m_pend > p)) begin tag = "R3"; bounce(s); end
    else begin
      tag = "R4";
      if (m_src != 0) bounce(m_src);
      m_src = s; m_pend = p;
    end
    @(posedge clk); #1;
    req_valid = 0;
    check_outputs();
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [31:0] d);
    logic [7:0] old;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_data = d; req_valid = 0;
    clear_expect();
    case (op)
      2'd0: begin
        old = m_cppr; m_cppr = d[7:0];
        if (d[7:0] < old) begin
          tag = "R7";
          if (m_src != 0 && !(d[7:0] > m_pend)) begin
            bounce(m_src); m_src = 0; m_pend = 8'hFF;
          end
        end else begin
          tag = "R8";
          if (m_src == 0) m_resend();
        end
      end
      2'd1: begin
        tag = "R6";
        m_mfrr = d[7:0];
        if (d[7:0] < m_cppr) m_ipi(d[7:0]);
      end
      2'd2: begin
        tag = "R5";
        #1 chk("R5", acc_data, {m_cppr, m_src});
        m_cppr = m_pend; m_src = 0; m_pend = 8'hFF;
      end
      default: begin
        tag = "R9";
        m_cppr = d[31:24];
        e_eoi = 1; e_eoi_src = d[23:0];
        if (m_src == 0) m_resend();
      end
    endcase
    @(posedge clk); #1;
    cmd_valid = 0;
    check_outputs();
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED);
    m_cppr = 0; m_src = 0; m_pend = 8'hFF; m_mfrr = 8'hFF;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1: reset state
    chk("R1", {31'd0, irq_out}, 32'd0);
    chk("R1", acc_data, 32'd0);
    chk("R1", {29'd0, rej_valid, resend_pulse, eoi_valid}, 32'd0);
    // R2: current priority 0 turns everything away
    do_req(24'd9, 8'h00);
    // R5: accept from reset opens the gate to 0xFF
    do_cmd(2'd2, 32'd0);
    // R8: raise with nothing pending; IPI priority 0xFF stays silent (R1)
    do_cmd(2'd0, 32'h0000_00FF);
    chk("R1", {8'd0, acc_data[23:0]}, 32'd0);
    // R4 then R3 tie, then preemption
    do_req(24'd5, 8'h10);
    do_req(24'd6, 8'h10);
    do_req(24'd7, 8'h08);
    // R2 boundary: equal to current priority
    do_cmd(2'd0, 32'h0000_0008);
    do_req(24'd11, 8'h08);
    // R11
    do_req(24'd0, 8'h01);
    // R6 tie with pending is blocked, then wins
    do_cmd(2'd0, 32'h0000_00F0);
    do_req(24'd12, 8'h20);
    do_cmd(2'd1, 32'h0000_0020);
    do_cmd(2'd1, 32'h0000_001F);
    // R7 drop onto pending priority
    do_cmd(2'd0, 32'h0000_001F);
    // R9 with nothing pending triggers IPI through resend
    do_cmd(2'd3, 32'h3000_0002);
    do_cmd(2'd2, 32'd0);
    do_cmd(2'd3, 32'hFF00_0002);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      case ($urandom % 8)
        0, 1, 2: do_req(24'($urandom % 12), pick_prio());
        3: do_cmd(2'd0, {24'd0, pick_prio()});
        4: do_cmd(2'd1, {24'd0, pick_prio()});
        5: do_cmd(2'd2, 32'd0);
        default: do_cmd(2'd3, {pick_prio(), 24'($urandom % 12)});
      endcase
    end
    done = 1;
    finish_run();
  end
endmodule